// File: doc/BRIEF.md
# Programmable Interrupt Source Router

This block sits between up to 32 peripheral interrupt request lines and the nine general-purpose event inputs of a core event controller, levels 7 through 15. Each source owns a small programmable field that names its target level, and one enable bit. On every clock, the block ORs together all sources that are active, enabled and aimed at the same level. It presents the result as one registered request line per level.

Software reaches the block through a simple word-wide register port. The port has three kinds of register:

- an enable register, with one bit per source;
- a read-only view of the raw request lines;
- a set of assignment words, each packing several 4-bit target fields.

At reset every source receives a fixed default target, so that interrupts route usefully before any software runs. Software may retarget any source at run time, and the next clock edge applies the new target. The priority and nesting logic of the core controller is out of scope, and so is wakeup handling.

Top module: `irq_source_router`

## Requirements
- R1: After reset, `lvl_req` is 0 and the enable register (address 0) reads 0. Source s has target field s mod 9, so the word at address 2 reads 0x76543210 and the word at address 3 reads 0x65432108.
- R2: With the default targets and all enables set, an active source s raises only `lvl_req` bit (s mod 9).
- R3: The target field of source s sits at address 2 + s/8, bits [4*(s%8)+3 : 4*(s%8)]. A field value v in 0..8 routes the source to level 7+v, which is `lvl_req` bit v.
- R4: A source whose field holds a value from 9 to 15 raises no request bit.
- R5: A source whose enable bit (address 0, bit s) is 0 raises no request bit, whatever its level or field.
- R6: Each `lvl_req` bit is the OR of all active, enabled sources that target that level. Dropping any one of several contributors keeps the bit set while another remains.
- R7: `lvl_req` is registered once. After each rising edge it equals the routing of the request lines, enables and targets that held before that edge. A register write therefore takes effect in the request computed at the following edge.
- R8: Address 1 reads the current raw `src_irq` lines. A write to address 1 changes no register.
- R9: The enable and assignment words read back the last value written. Addresses 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_irq | input | 32 | Peripheral request lines, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| lvl_req | output | 9 | Registered request per level; bit v is level 7+v |

## Verification
The first pattern drives single active sources under the default targets. It shows whether each source lands on its own level or spills onto a neighbour.

Run-time rewrites of one field, first to the top level and then to an out-of-range value, separate a correct field decode from one that drops or aliases values above 8. Several sources on one level, with their enables removed one by one, separate a true OR from last-writer logic. Long runs of random request lines mixed with random register writes, compared each cycle against a behavioural model, expose off-by-one latency and write-ordering faults.

// File: rtl/isr_pkg.sv
package isr_pkg;
   localparam int unsigned ADDR_ENABLE = 0;
   localparam int unsigned ADDR_STATUS = 1;
   localparam int unsigned ADDR_ASG0   = 2;

   // reset target for a source: spread sources round-robin over the levels
   function automatic int unsigned default_target(input int unsigned src, input int unsigned nlvl);
      return src % nlvl;
   endfunction
endpackage

// File: rtl/isr_regfile.sv
module isr_regfile #(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned NUM_LVL = 9,
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 3
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       we,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          rdata,
   input  logic [NUM_SRC-1:0]         src_irq,
   output logic [NUM_SRC-1:0]         enable_o,
   output logic [NUM_SRC*FIELD_W-1:0] target_o
);
   localparam int unsigned FPW    = DATA_W / FIELD_W;
   localparam int unsigned NWORDS = (NUM_SRC + FPW - 1) / FPW;
   localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(isr_pkg::ADDR_ENABLE);
   localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(isr_pkg::ADDR_STATUS);

   if (NUM_SRC > DATA_W) begin : g_err_src
      $error("NUM_SRC exceeds DATA_W");
   end
   if (DATA_W % FIELD_W != 0) begin : g_err_fld
      $error("DATA_W must be a multiple of FIELD_W");
   end
   if (isr_pkg::ADDR_ASG0 + NWORDS > (1 << ADDR_W)) begin : g_err_addr
      $error("address space too small for assignment words");
   end
   if (NUM_LVL > (1 << FIELD_W)) begin : g_err_lvl
      $error("FIELD_W too narrow for NUM_LVL");
   end

   logic [NUM_SRC-1:0] enable_q;
   logic [DATA_W-1:0]  tgt_rd [NUM_SRC];

   always_ff @(posedge clk) begin
      if (rst)                    enable_q <= '0;
      else if (we && addr == A_EN) enable_q <= wdata[NUM_SRC-1:0];
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      localparam logic [ADDR_W-1:0]  WADDR = ADDR_W'(isr_pkg::ADDR_ASG0 + s / FPW);
      localparam int unsigned        LSB   = (s % FPW) * FIELD_W;
      localparam logic [FIELD_W-1:0] RVAL  = FIELD_W'(isr_pkg::default_target(s, NUM_LVL));
      logic [FIELD_W-1:0] q;

      always_ff @(posedge clk) begin
         if (rst)                      q <= RVAL;
         else if (we && addr == WADDR) q <= wdata[LSB +: FIELD_W];
      end

      assign target_o[s*FIELD_W +: FIELD_W] = q;
      assign tgt_rd[s] = (addr == WADDR) ? (DATA_W'(q) << LSB) : '0;
   end

   always_comb begin
      rdata = '0;
      if (addr == A_EN)      rdata = DATA_W'(enable_q);
      else if (addr == A_ST) rdata = DATA_W'(src_irq);
      else begin
         for (int s = 0; s < NUM_SRC; s++) rdata = rdata | tgt_rd[s];
      end
   end

   assign enable_o = enable_q;

   // R8: a write aimed at the status view never disturbs the enables
   a_r8_status_write_ignored : assert property (@(posedge clk) disable iff (rst)
      (we && addr == A_ST) |=> $stable(enable_q));
   // R9: without a write strobe the enables hold their value
   a_r9_enable_holds : assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(enable_q));
endmodule

// File: rtl/isr_level_or.sv
module isr_level_or #(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned NUM_LVL = 9,
   parameter int unsigned FIELD_W = 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NUM_SRC-1:0]         src_irq,
   input  logic [NUM_SRC-1:0]         enable,
   input  logic [NUM_SRC*FIELD_W-1:0] target,
   output logic [NUM_LVL-1:0]         lvl_req
);
   logic [NUM_SRC-1:0] live;
   logic [NUM_LVL-1:0] req_d;

   assign live = src_irq & enable;

   for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
      logic [NUM_SRC-1:0] aimed;
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
         assign aimed[s] = (target[s*FIELD_W +: FIELD_W] == FIELD_W'(k));
      end
      assign req_d[k] = |(aimed & live);
   end

   always_ff @(posedge clk) begin
      if (rst) lvl_req <= '0;
      else     lvl_req <= req_d;
   end

   // R5: with no enabled active source, no level is requested next cycle
   a_r5_masked_silent : assert property (@(posedge clk) disable iff (rst)
      (live == '0) |=> (lvl_req == '0));
   // R3: a single live source reaches at most one level
   a_r3_single_target : assert property (@(posedge clk) disable iff (rst)
      ($countones(live) == 1) |=> $onehot0(lvl_req));
endmodule

// File: rtl/irq_source_router.sv
module irq_source_router #(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned NUM_LVL = 9,
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] src_irq,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic [NUM_LVL-1:0] lvl_req
);
   logic [NUM_SRC-1:0]         enable;
   logic [NUM_SRC*FIELD_W-1:0] target;

   isr_regfile #(
      .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .FIELD_W(FIELD_W),
      .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst      (rst),
      .we       (reg_we),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .src_irq  (src_irq),
      .enable_o (enable),
      .target_o (target)
   );

   isr_level_or #(
      .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .FIELD_W(FIELD_W)
   ) u_or (
      .clk     (clk),
      .rst     (rst),
      .src_irq (src_irq),
      .enable  (enable),
      .target  (target),
      .lvl_req (lvl_req)
   );

   // R7: with the enables cleared the previous cycle, the output stays quiet
   a_r7_disabled_quiet : assert property (@(posedge clk) disable iff (rst)
      (enable == '0) |=> (lvl_req == '0));
endmodule

// File: tb/tb_irq_source_router.sv
module tb_irq_source_router;
   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] src_irq;
   logic        reg_we;
   logic [2:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic [8:0]  lvl_req;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   irq_source_router dut (
      .clk(clk), .rst(rst), .src_irq(src_irq), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .lvl_req(lvl_req)
   );

   always #5 clk = ~clk;

   // behavioural reference model
   int          m_tgt [32];
   logic [31:0] m_en;
   logic [8:0]  m_exp;

   function automatic logic [8:0] route(input logic [31:0] src, input logic [31:0] en);
      logic [8:0] r = '0;
      for (int s = 0; s < 32; s++)
         if (src[s] && en[s] && m_tgt[s] < 9) r[m_tgt[s]] = 1'b1;
      return r;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (rst) begin
         m_exp = '0;
         m_en  = '0;
         for (int s = 0; s < 32; s++) m_tgt[s] = s % 9;
      end else begin
         m_exp = route(src_irq, m_en);
         if (reg_we) begin
            if (reg_addr == 3'd0) m_en = reg_wdata;
            if (reg_addr >= 3'd2 && reg_addr <= 3'd5)
               for (int j = 0; j < 8; j++)
                  m_tgt[(int'(reg_addr) - 2) * 8 + j] = int'(reg_wdata[j*4 +: 4]);
         end
      end
      #2;
      if (!done) check("R7 per-cycle model", 32'(lvl_req), 32'(m_exp));
   end

   task automatic tick();
      @(posedge clk);
      #3;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      check(tag, reg_rdata, exp);
   endtask

   task automatic finish_run();
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired at %0t", $time);
      finish_run();
   end

   initial begin
      rst = 1'b1; src_irq = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
      repeat (3) @(posedge clk);
      #3 rst = 1'b0;

      // R1 reset state
      check("R1 lvl_req", 32'(lvl_req), 32'h0);
      rd("R1 enable", 3'd0, 32'h0);
      rd("R1 word2", 3'd2, 32'h7654_3210);
      rd("R1 word3", 3'd3, 32'h6543_2108);

      // R5 all active but disabled
      src_irq = 32'hFFFF_FFFF;
      tick(); tick();
      check("R5 all disabled", 32'(lvl_req), 32'h0);

      // R2 default targets
      src_irq = 32'h1 << 10;
      wr(3'd0, 32'hFFFF_FFFF);
      tick();
      check("R2 src10 default", 32'(lvl_req), 32'h002);

      // R7 latency: output holds until the next edge
      src_irq = 32'h1 << 4;
      #1;
      check("R7 holds before edge", 32'(lvl_req), 32'h002);
      tick();
      check("R7 src4 after edge", 32'(lvl_req), 32'h010);

      // R3 retarget source 10 to level 15
      src_irq = 32'h1 << 10;
      wr(3'd3, 32'h6543_2808);
      tick();
      check("R3 src10 field 8", 32'(lvl_req), 32'h100);

      // R4 out-of-range field
      wr(3'd3, 32'h6543_2F08);
      tick();
      check("R4 src10 field F", 32'(lvl_req), 32'h0);
      rd("R9 word3 readback", 3'd3, 32'h6543_2F08);

      // R6 several sources share level 7
      wr(3'd3, 32'h6543_2108);
      src_irq = (32'h1 << 0) | (32'h1 << 9) | (32'h1 << 18);
      tick(); tick();
      check("R6 three share lvl", 32'(lvl_req), 32'h001);
      wr(3'd0, 32'hFFFF_FFFE);
      tick();
      check("R6 one dropped", 32'(lvl_req), 32'h001);
      src_irq = 32'h1;
      tick();
      check("R5 src0 disabled", 32'(lvl_req), 32'h0);

      // R8 status view
      src_irq = 32'hA5A5_0F0F;
      rd("R8 status read", 3'd1, 32'hA5A5_0F0F);
      wr(3'd1, 32'h0);
      rd("R8 enable kept", 3'd0, 32'hFFFF_FFFE);
      rd("R8 status still raw", 3'd1, 32'hA5A5_0F0F);

      // R9 unmapped addresses
      rd("R9 addr6 zero", 3'd6, 32'h0);
      wr(3'd7, 32'h1234_5678);
      rd("R9 addr7 zero", 3'd7, 32'h0);
      rd("R9 enable after addr7", 3'd0, 32'hFFFF_FFFE);
      rd("R9 word2 after addr7", 3'd2, 32'h7654_3210);

      // random traffic against the per-cycle model
      for (int i = 0; i < 400; i++) begin
         src_irq = $urandom;
         if ($urandom_range(3, 0) == 0) begin
            reg_we    = 1'b1;
            reg_addr  = 3'($urandom_range(7, 0));
            reg_wdata = $urandom;
         end else begin
            reg_we = 1'b0;
         end
         tick();
      end
      reg_we = 1'b0;
      tick(); tick();
      finish_run();
   end
endmodule